// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data memory addresses for indirect operand access. It holds four address pointers, four modify values and four length values. Software or a controller loads all of them through one register-write port. On each access request the caller names one pointer and one modify register. The block drives the pointer's current value as the address. In the same clock edge it replaces the pointer with its post-modified value.

When a pointer's length is zero, the update is a plain two's-complement add that wraps at the 14-bit address width. When the length is non-zero, the pointer moves inside a circular buffer. The buffer's base is fixed when the pointer is written, and the update folds back by the length so the address stays inside the window. Negative modify values fold back the same way. To get the intended base, write a pointer's length before its pointer value.

Top module: `circ_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `addr` is 0 and `addr_valid` is 0. All pointer, modify and length registers reset to 0.
- R2: A write with `wr_en` high stores `wr_data` in a register selected by `wr_sel`, where 0 selects a pointer, 1 a modify value and 2 a length. `wr_idx` picks which of the four registers. The new value is in effect from the next cycle. A write with `wr_sel` = 3 changes nothing.
- R3: A request (`req` high at a rising edge) makes `addr` equal to the selected pointer's value from before the update, starting the next cycle. `addr_valid` is high for exactly the cycles that follow a request cycle and low otherwise.
- R4: With length 0, a request sets the pointer to pointer + modify, where the modify value is read as signed 14-bit and the sum wraps modulo 2^14.
- R5: With a non-zero length L and a non-negative modify value, an update whose offset from the base would reach L or more is reduced by L.
- R6: With a non-zero length L and a negative modify value, an update whose offset from the base would drop below zero is increased by L.
- R7: A pointer write latches that pointer's base as the written value rounded down to a multiple of the smallest power of two that is at least the current length. For example, length 10 gives an alignment of 16 and length 8 gives 8.
- R8: When a pointer write and a request target the same pointer in the same cycle, the written value is stored. The address output still shows the value from before the write.
- R9: Any pointer may be combined with any modify register. Requests on one pointer leave the other pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register class: 0 pointer, 1 modify, 2 length, 3 none |
| wr_idx | input | 2 | Register index within the class |
| wr_data | input | 14 | Value to write |
| req | input | 1 | Access request |
| req_ptr | input | 2 | Pointer select for the access |
| req_mod | input | 2 | Modify register select for the access |
| addr | output | 14 | Registered address (pre-update pointer) |
| addr_valid | output | 1 | High the cycle after a request |

## Verification
A wrong pointer update does not show up in the access that causes it. It first appears at `addr` on the next request to that same pointer, one cycle after that request. For this reason the stimulus reuses each pointer several times in a row and crosses the buffer edges in both directions. A wrongly latched base shows up at the first wrap. It appears as an address outside the window, or one that lands at the wrong offset. A lost or stray write shows up at the next access to the register concerned.

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW   = 14,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [AW-1:0]           wr_data,
  input  logic                    req,
  input  logic [$clog2(NREG)-1:0] req_ptr,
  input  logic [$clog2(NREG)-1:0] req_mod,
  output logic [AW-1:0]           addr,
  output logic                    addr_valid
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] SEL_PTR = 2'd0, SEL_MOD = 2'd1, SEL_LEN = 2'd2;

  logic [AW-1:0] ptr_q  [NREG];
  logic [AW-1:0] base_q [NREG];
  logic [AW-1:0] mod_q  [NREG];
  logic [AW-1:0] len_q  [NREG];

  function automatic logic [AW-1:0] win_mask(input logic [AW-1:0] l);
    logic [AW-1:0] m;
    m = l - 1'b1;
    for (int k = 1; k < AW; k++) m = m | (m >> k);
    return m;
  endfunction

  logic [AW-1:0] cur_ptr, cur_base, cur_mod, cur_len, lin_nxt, circ_nxt, nxt;
  logic signed [AW:0] off, sum, fold;

  assign cur_ptr  = ptr_q[req_ptr];
  assign cur_base = base_q[req_ptr];
  assign cur_mod  = mod_q[req_mod];
  assign cur_len  = len_q[req_ptr];
  assign lin_nxt  = cur_ptr + cur_mod;
  assign off      = $signed({1'b0, cur_ptr - cur_base});
  assign sum      = off + $signed({cur_mod[AW-1], cur_mod});

  always_comb begin
    fold = sum;
    if (sum < 0)
      fold = sum + $signed({1'b0, cur_len});
    else if (sum >= $signed({1'b0, cur_len}))
      fold = sum - $signed({1'b0, cur_len});
  end

  assign circ_nxt = cur_base + fold[AW-1:0];
  assign nxt      = (cur_len == '0) ? lin_nxt : circ_nxt;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[i]  <= '0;
        base_q[i] <= '0;
        mod_q[i]  <= '0;
        len_q[i]  <= '0;
      end else begin
        if (hit_wr && wr_sel == SEL_PTR) begin
          ptr_q[i]  <= wr_data;
          base_q[i] <= wr_data & ~win_mask(len_q[i]);
        end else if (req && req_ptr == IW'(i)) begin
          ptr_q[i]  <= nxt;
        end
        if (hit_wr && wr_sel == SEL_MOD) mod_q[i] <= wr_data;
        if (hit_wr && wr_sel == SEL_LEN) len_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= req;
      if (req) addr <= cur_ptr;
    end
  end

  logic wr_same;
  assign wr_same = wr_en && wr_sel == SEL_PTR && wr_idx == req_ptr;

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid);
  // R3
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_valid);
  // R3
  addr_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr == $past(ptr_q[req_ptr]));
  // R8
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PTR) |=> ptr_q[$past(wr_idx)] == $past(wr_data));
  // R2
  mod_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MOD) |=> mod_q[$past(wr_idx)] == $past(wr_data));
  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr_same && len_q[req_ptr] == '0) |=>
      ptr_q[$past(req_ptr)] == $past(ptr_q[req_ptr] + mod_q[req_mod]));
endmodule

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  localparam int CLK_T = 10;
  localparam int NV = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, req = 1'b0;
  logic [1:0] wr_sel = '0, wr_idx = '0, req_ptr = '0, req_mod = '0;
  logic [13:0] wr_data = '0;
  logic [13:0] addr;
  logic addr_valid;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  circ_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .req(req), .req_ptr(req_ptr), .req_mod(req_mod),
    .addr(addr), .addr_valid(addr_valid)
  );

  // {access, f1, f2, data}: write -> f1=class f2=index; access -> f1=pointer f2=modify, data=expected addr
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd2, 2'd0, 14'd0},       // R2 len0=0
    {1'b0, 2'd1, 2'd0, 14'd3},       // R2 mod0=3
    {1'b0, 2'd1, 2'd1, 14'h3FFE},    // R2 mod1=-2
    {1'b0, 2'd1, 2'd2, 14'd5},       // R2 mod2=5
    {1'b0, 2'd1, 2'd3, 14'd1},       // R2 mod3=1
    {1'b0, 2'd0, 2'd0, 14'd100},     // R2 ptr0=100
    {1'b1, 2'd0, 2'd0, 14'd100},     // R3 R4
    {1'b1, 2'd0, 2'd1, 14'd103},     // R4
    {1'b1, 2'd0, 2'd1, 14'd101},     // R4
    {1'b0, 2'd2, 2'd1, 14'd10},      // len1=10
    {1'b0, 2'd0, 2'd1, 14'd37},      // R7 base 32
    {1'b1, 2'd1, 2'd2, 14'd37},      // R5
    {1'b1, 2'd1, 2'd2, 14'd32},      // R5 wrapped
    {1'b1, 2'd1, 2'd1, 14'd37},
    {1'b1, 2'd1, 2'd1, 14'd35},
    {1'b1, 2'd1, 2'd1, 14'd33},      // R6 next wraps to 41
    {1'b1, 2'd1, 2'd3, 14'd41},      // R6
    {1'b1, 2'd1, 2'd0, 14'd32},      // R5
    {1'b0, 2'd2, 2'd2, 14'd8},       // len2=8
    {1'b0, 2'd0, 2'd2, 14'd19},      // R7 base 16
    {1'b1, 2'd2, 2'd0, 14'd19},
    {1'b1, 2'd2, 2'd0, 14'd22},
    {1'b1, 2'd2, 2'd0, 14'd17},      // R5
    {1'b0, 2'd0, 2'd3, 14'h3FFF},
    {1'b1, 2'd3, 2'd3, 14'h3FFF},    // R4 top of range
    {1'b1, 2'd3, 2'd3, 14'd0},       // R4 wrapped
    {1'b0, 2'd3, 2'd0, 14'h1234},    // R2 class 3 ignored
    {1'b1, 2'd0, 2'd3, 14'd99},      // R2 ptr0 untouched
    {1'b0, 2'd0, 2'd2, 14'h45},      // R7 base 0x40
    {1'b1, 2'd2, 2'd2, 14'h45},
    {1'b1, 2'd2, 2'd2, 14'h42},      // R5
    {1'b1, 2'd2, 2'd2, 14'h47},
    {1'b1, 2'd1, 2'd0, 14'd35}       // R9 pointer 1 kept its value
  };

  task automatic check(input string tag, input logic [13:0] got, input logic [13:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 addr in reset", addr, 14'd0);
    check("R1 valid in reset", {13'd0, addr_valid}, 14'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 addr after reset", addr, 14'd0);
    check("R1 valid after reset", {13'd0, addr_valid}, 14'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b0; req = 1'b0;
      if (VEC[i][18]) begin
        req = 1'b1; req_ptr = VEC[i][17:16]; req_mod = VEC[i][15:14];
      end else begin
        wr_en = 1'b1; wr_sel = VEC[i][17:16]; wr_idx = VEC[i][15:14]; wr_data = VEC[i][13:0];
      end
      @(posedge clk); #1;
      wr_en = 1'b0; req = 1'b0;
      if (VEC[i][18]) begin
        check($sformatf("R3 table row %0d addr", i), addr, VEC[i][13:0]);
        check($sformatf("R3 table row %0d valid", i), {13'd0, addr_valid}, 14'd1);
      end else begin
        check($sformatf("R3 table row %0d valid low", i), {13'd0, addr_valid}, 14'd0);
      end
    end

    // R8: pointer 0 holds 100; write 200 and access it in the same cycle
    @(negedge clk);
    req = 1'b1; req_ptr = 2'd0; req_mod = 2'd0;
    wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 2'd0; wr_data = 14'd200;
    @(posedge clk); #1;
    wr_en = 1'b0; req = 1'b0;
    check("R8 addr shows pre-write value", addr, 14'd100);
    @(negedge clk);
    req = 1'b1; req_ptr = 2'd0; req_mod = 2'd3;
    @(posedge clk); #1;
    req = 1'b0;
    check("R8 write wins over update", addr, 14'd200);
    @(posedge clk); #1;
    check("R3 valid drops when idle", {13'd0, addr_valid}, 14'd0);
    check("R3 addr held when idle", addr, 14'd200);

    finish_run();
  end
endmodule